// File: doc/BRIEF.md
# Byte-Wide FPGA Configuration Sequencer

This block loads a configuration image into a downstream FPGA through its byte-wide parallel configuration port. After a start request it pulses the program line and waits for the target to clear its memory. It then opens the port and clocks the image in one byte per configuration-clock cycle. The image arrives on a valid/ready byte stream, and its length is given with the start request. At the end it waits for the target to report completion. The outcome is posted as a one-cycle result with a pass flag and a cause code.

The same port can be read instead. In that mode the block selects the target, clocks the requested number of bytes out, and presents each byte on a one-cycle output strobe. It then deselects the target and gives one trailing clock.

All long waits (program acknowledge, memory clear, settling, busy throttle, completion) are measured in milliseconds. A prescaler turns the system clock into millisecond ticks, so each wait is set by a parameter.

Top module: `cfg_loader`

## Requirements
- R1: A start request is taken only while `busy` is low. `busy` rises in the cycle after an accepted start and stays high until the cycle in which `res_valid` pulses. A start request that arrives while `busy` is high has no effect.
- R2: A load first drives `prog_n` low for at least `PROG_CYCLES` clock cycles. It releases `prog_n` only after `init_n` has been seen low. If `init_n` does not go low within `INIT_MS` milliseconds, the load ends with code 1.
- R3: After `prog_n` is released, the block waits for `init_n` to return high, with an `INIT_MS` timeout that gives code 2. `cs_n` and `write_n` go low together, and only after `init_n` has been seen high.
- R4: At least `SETTLE_MS` milliseconds pass between `cs_n` going low and the first falling edge of `cclk`.
- R5: For each byte, `d_out` is driven with `d_oe` high one cycle before `cclk` falls. `cclk` stays low for one cycle and then rises, with `d_out` unchanged across the rise. Bytes go out in stream order, and exactly `byte_count` of them are sent.
- R6: If `init_n` is low in any cycle while bytes are being sent, the load ends at once with code 3.
- R7: When `busy_check` was high at start, the block holds off after each rising `cclk` until `busy_in` is low. If `busy_in` stays high for more than `BUSY_MS` milliseconds, the load ends with code 4. When `busy_check` was low, `busy_in` is ignored.
- R8: After the last byte, `cs_n` returns high one cycle before `write_n` does. The load passes (code 0, `res_ok` high) only if `done_in` and `init_n` are both seen high within `DONE_MS` milliseconds. Otherwise it ends with code 5.
- R9: In readback mode, `cs_n` goes low with `write_n` high. Each byte is one low-then-high `cclk` cycle, and `d_in` is sampled after the rise and shown on `rd_data` with a one-cycle `rd_valid`. Then `cs_n` goes high and exactly one more `cclk` cycle follows. The result is code 0.
- R10: While `busy` is low, and after every abort, `prog_n`, `cs_n` and `write_n` are high and `d_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request, taken while idle |
| readback | input | 1 | With start: 1 selects readback, 0 selects load |
| busy_check | input | 1 | With start: enable the busy throttle |
| byte_count | input | CW | With start: number of bytes to move |
| in_data | input | 8 | Image byte |
| in_valid | input | 1 | Image byte valid |
| in_ready | output | 1 | Block takes the byte this cycle |
| prog_n | output | 1 | Program line to target, active low |
| cs_n | output | 1 | Port select to target, active low |
| write_n | output | 1 | Write direction to target, active low |
| cclk | output | 1 | Configuration clock to target |
| d_out | output | 8 | Data driven toward target |
| d_oe | output | 1 | Output enable for d_out |
| d_in | input | 8 | Data read from target |
| init_n | input | 1 | Target init/error line, low while clearing or on error |
| busy_in | input | 1 | Target busy |
| done_in | input | 1 | Target configuration done |
| busy | output | 1 | Operation in progress |
| rd_data | output | 8 | Readback byte |
| rd_valid | output | 1 | rd_data valid for one cycle |
| res_valid | output | 1 | Result strobe, one cycle |
| res_ok | output | 1 | Operation passed |
| res_code | output | 3 | 0 pass, 1 init-low timeout, 2 init-high timeout, 3 init dropped, 4 busy timeout, 5 done timeout |

## Verification
The assertions assume that `init_n`, `busy_in`, `done_in` and `d_in` are synchronous to `clk`. They also assume that `d_in` holds steady from a rising `cclk` until the next falling one. The bench target model changes these inputs only on the falling edge of `clk`, and it changes `d_in` only when `cclk` falls. The model lowers `init_n` a few cycles into the program pulse and raises it again after release, unless a test holds it stuck. It raises `done_in` only once the full byte count has arrived and the port is closed, which keeps each input inside the handshake the properties rely on.

// File: rtl/cfg_loader.sv
module cfg_loader #(
  parameter int TICK_DIV    = 100000,
  parameter int INIT_MS     = 500,
  parameter int SETTLE_MS   = 10,
  parameter int BUSY_MS     = 5,
  parameter int DONE_MS     = 200,
  parameter int PROG_CYCLES = 32,
  parameter int CW          = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          readback,
  input  logic          busy_check,
  input  logic [CW-1:0] byte_count,
  input  logic [7:0]    in_data,
  input  logic          in_valid,
  output logic          in_ready,
  output logic          prog_n,
  output logic          cs_n,
  output logic          write_n,
  output logic          cclk,
  output logic [7:0]    d_out,
  output logic          d_oe,
  input  logic [7:0]    d_in,
  input  logic          init_n,
  input  logic          busy_in,
  input  logic          done_in,
  output logic          busy,
  output logic [7:0]    rd_data,
  output logic          rd_valid,
  output logic          res_valid,
  output logic          res_ok,
  output logic [2:0]    res_code
);
  localparam int M1 = (INIT_MS > DONE_MS) ? INIT_MS : DONE_MS;
  localparam int M2 = (SETTLE_MS > BUSY_MS) ? SETTLE_MS : BUSY_MS;
  localparam int MMAX = (M1 > M2) ? M1 : M2;
  localparam int MW = $clog2(MMAX + 2);
  localparam int PW = $clog2(TICK_DIV + 1);
  localparam int QW = $clog2(PROG_CYCLES + 1);

  localparam logic [2:0] C_OK = 3'd0, C_INIT_LO = 3'd1, C_INIT_HI = 3'd2,
                         C_CFG = 3'd3, C_BUSY = 3'd4, C_DONE = 3'd5;

  typedef enum logic [4:0] {
    S_IDLE, S_PROG, S_WHI, S_SETTLE, S_LOAD, S_DATA, S_CLO, S_CHI, S_BUSY,
    S_CLOSE, S_CLOSE2, S_DONE, S_RCS, S_RLO, S_RHI, S_REND, S_RELO, S_REHI
  } st_t;

  st_t st, nxt;
  logic [CW-1:0] rem;
  logic rb_q, bchk_q;
  logic [PW-1:0] pre;
  logic [MW-1:0] ms, lim;
  logic [QW-1:0] pcnt;
  logic fin, f_ok, take, expired, streaming;
  logic [2:0] f_code;

  assign busy      = (st != S_IDLE);
  assign streaming = (st == S_LOAD) || (st == S_DATA) || (st == S_CLO) ||
                     (st == S_CHI) || (st == S_BUSY);
  assign prog_n    = (st != S_PROG);
  assign write_n   = !(streaming || st == S_SETTLE || st == S_CLOSE);
  assign cs_n      = !(streaming || st == S_SETTLE || st == S_RCS ||
                       st == S_RLO || st == S_RHI);
  assign cclk      = !(st == S_CLO || st == S_RLO || st == S_RELO);
  assign d_oe      = (st == S_DATA) || (st == S_CLO) || (st == S_CHI) || (st == S_BUSY);
  assign in_ready  = (st == S_LOAD) && init_n;
  assign take      = in_ready && in_valid;
  assign expired   = (ms >= lim);

  always_comb begin
    case (st)
      S_SETTLE: lim = MW'(SETTLE_MS);
      S_BUSY:   lim = MW'(BUSY_MS);
      S_DONE:   lim = MW'(DONE_MS);
      default:  lim = MW'(INIT_MS);
    endcase
  end

  always_comb begin
    nxt = st; fin = 1'b0; f_ok = 1'b0; f_code = C_OK;
    case (st)
      S_IDLE:   if (start) nxt = readback ? S_RCS : S_PROG;
      S_PROG:
        if (pcnt >= QW'(PROG_CYCLES - 1) && !init_n) nxt = S_WHI;
        else if (expired) begin nxt = S_IDLE; fin = 1'b1; f_code = C_INIT_LO; end
      S_WHI:
        if (init_n) nxt = S_SETTLE;
        else if (expired) begin nxt = S_IDLE; fin = 1'b1; f_code = C_INIT_HI; end
      S_SETTLE: if (expired) nxt = (rem == '0) ? S_CLOSE : S_LOAD;
      S_LOAD:   if (take) nxt = S_DATA;
      S_DATA:   nxt = S_CLO;
      S_CLO:    nxt = S_CHI;
      S_CHI:    nxt = bchk_q ? S_BUSY : ((rem == '0) ? S_CLOSE : S_LOAD);
      S_BUSY:
        if (!busy_in) nxt = (rem == '0) ? S_CLOSE : S_LOAD;
        else if (expired) begin nxt = S_IDLE; fin = 1'b1; f_code = C_BUSY; end
      S_CLOSE:  nxt = S_CLOSE2;
      S_CLOSE2: nxt = S_DONE;
      S_DONE:
        if (done_in && init_n) begin nxt = S_IDLE; fin = 1'b1; f_ok = 1'b1; end
        else if (expired) begin nxt = S_IDLE; fin = 1'b1; f_code = C_DONE; end
      S_RCS:    nxt = (rem == '0) ? S_REND : S_RLO;
      S_RLO:    nxt = S_RHI;
      S_RHI:    nxt = (rem == CW'(1)) ? S_REND : S_RLO;
      S_REND:   nxt = S_RELO;
      S_RELO:   nxt = S_REHI;
      S_REHI:   begin nxt = S_IDLE; fin = 1'b1; f_ok = 1'b1; end
      default:  nxt = S_IDLE;
    endcase
    if (streaming && !init_n) begin
      nxt = S_IDLE; fin = 1'b1; f_ok = 1'b0; f_code = C_CFG;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; rem <= '0; rb_q <= 1'b0; bchk_q <= 1'b0;
      pre <= '0; ms <= '0; pcnt <= '0; d_out <= '0;
      rd_data <= '0; rd_valid <= 1'b0;
      res_valid <= 1'b0; res_ok <= 1'b0; res_code <= C_OK;
    end else begin
      st <= nxt;
      rd_valid <= 1'b0;
      res_valid <= fin;
      if (fin) begin res_ok <= f_ok; res_code <= f_code; end
      if (st == S_IDLE && start) begin
        rem <= byte_count; rb_q <= readback; bchk_q <= busy_check;
      end
      if (take) begin d_out <= in_data; rem <= rem - 1'b1; end
      if (st == S_RHI) begin
        rd_data <= d_in; rd_valid <= 1'b1; rem <= rem - 1'b1;
      end
      if (st != nxt) begin
        pre <= '0; ms <= '0; pcnt <= '0;
      end else begin
        if (pcnt != QW'(PROG_CYCLES)) pcnt <= pcnt + 1'b1;
        if (pre == PW'(TICK_DIV - 1)) begin
          pre <= '0;
          if (ms != '1) ms <= ms + 1'b1;
        end else pre <= pre + 1'b1;
      end
    end
  end

  p_idle_released_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (prog_n && cs_n && write_n && !d_oe));
  p_busy_to_result_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> res_valid);
  p_prog_needs_init_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(prog_n) && busy) |-> !$past(init_n));
  p_open_after_init_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_n) && !write_n) |-> $past(init_n));
  p_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cclk) && d_oe) |-> $stable(d_out));
  p_init_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (streaming && !init_n) |=> (!busy && res_valid && res_code == C_CFG));
  p_cs_before_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(write_n) && busy) |-> $past(cs_n));
  p_pass_needs_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ok && !rb_q) |-> ($past(done_in) && $past(init_n)));
endmodule

// File: tb/cfg_loader_bench.sv
module cfg_loader_bench;
  localparam int TICK = 4, INIT_MS = 10, SETTLE_MS = 2, BUSY_MS = 3, DONE_MS = 10;
  localparam int PROGC = 5, CW = 8;

  logic clk = 0, rst_n = 0;
  logic start = 0, readback = 0, busy_check = 0, in_valid = 0;
  logic [CW-1:0] byte_count = '0;
  logic [7:0] in_data = '0, d_in = '0, d_out, rd_data;
  logic init_n = 1, busy_in = 0, done_in = 0;
  logic in_ready, prog_n, cs_n, write_n, cclk, d_oe, busy, rd_valid;
  logic res_valid, res_ok;
  logic [2:0] res_code;

  always #5 clk = ~clk;

  cfg_loader #(.TICK_DIV(TICK), .INIT_MS(INIT_MS), .SETTLE_MS(SETTLE_MS),
               .BUSY_MS(BUSY_MS), .DONE_MS(DONE_MS), .PROG_CYCLES(PROGC), .CW(CW))
  u_cfg_loader (.clk, .rst_n, .start, .readback, .busy_check, .byte_count,
    .in_data, .in_valid, .in_ready, .prog_n, .cs_n, .write_n, .cclk, .d_out,
    .d_oe, .d_in, .init_n, .busy_in, .done_in, .busy, .rd_data, .rd_valid,
    .res_valid, .res_ok, .res_code);

  int checks = 0, errors = 0;
  logic [7:0] q_w[$], q_r[$];
  logic [3:0] q_res[$];

  bit m_lo_ok = 1, m_hi_ok = 1, m_done_ok = 1;
  int m_drop = -1, m_busy_len = 0, m_expect = 0;
  int cyc = 0, plo = 0, phi = 0, rx = 0, bcnt = 0, t_cs = 0, first_fall = 0;
  int cs_fells = 0, rb_cnt = 0, rb_tail = 0, rd_seen = 0;
  bit dropped = 0, cclk_q = 1, prog_q = 1, cs_q = 1;
  logic [7:0] rb_base = 8'h40;

  task automatic chk(bit cond, string req, int act, int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!prog_n) begin
      plo++;
      if (plo == 3 && m_lo_ok) init_n = 0;
      done_in = 0; rx = 0; dropped = 0; phi = 0;
    end
    if (prog_n && !prog_q && m_lo_ok) begin
      chk(plo >= PROGC, "R2 pulse width", plo, PROGC);
      chk(init_n == 0, "R2 init low before release", init_n, 0);
    end
    if (prog_n) plo = 0;
    if (prog_n && !init_n && !dropped && m_hi_ok) begin
      phi++;
      if (phi == 4) init_n = 1;
    end
    if (!cs_n && cs_q && !write_n) begin
      cs_fells++; t_cs = cyc; first_fall = 1;
      chk(init_n == 1, "R3 open after init high", init_n, 1);
    end
    if (!cclk && cclk_q && !cs_n && !write_n) begin
      chk(d_oe == 1, "R5 data before clock", d_oe, 1);
      if (first_fall) begin
        chk(cyc - t_cs >= SETTLE_MS * TICK, "R4 settle", cyc - t_cs, SETTLE_MS * TICK);
        first_fall = 0;
      end
    end
    if (bcnt > 0) begin
      bcnt--;
      if (bcnt == 0) busy_in = 0;
    end
    if (cclk && !cclk_q && !cs_n && !write_n) begin
      if (q_w.size() == 0) chk(0, "R5 unexpected byte", d_out, -1);
      else begin
        logic [7:0] e;
        e = q_w.pop_front();
        chk(d_out == e, "R5 byte order", d_out, e);
      end
      rx++;
      if (rx == m_drop) begin init_n = 0; dropped = 1; end
      if (m_busy_len > 0) begin busy_in = 1; bcnt = m_busy_len; end
    end
    if (!cclk && cclk_q && !cs_n && write_n) begin
      rb_cnt++; d_in = rb_base + 8'(rb_cnt);
    end
    if (cclk && !cclk_q && cs_n && write_n && prog_n && busy) rb_tail++;
    if (m_done_ok && m_lo_ok && prog_n && cs_n && write_n && init_n && rx == m_expect && !dropped)
      done_in = 1;
    if (rd_valid) begin
      rd_seen++;
      if (q_r.size() == 0) chk(0, "R9 unexpected read", rd_data, -1);
      else begin
        logic [7:0] e;
        e = q_r.pop_front();
        chk(rd_data == e, "R9 read data", rd_data, e);
      end
    end
    if (res_valid) begin
      if (q_res.size() == 0) chk(0, "R1 unexpected result", {res_ok, res_code}, -1);
      else begin
        logic [3:0] e;
        e = q_res.pop_front();
        chk({res_ok, res_code} == e, "R1/R8 result", {res_ok, res_code}, e);
      end
    end
    cclk_q = cclk; prog_q = prog_n; cs_q = cs_n;
  end

  task automatic launch(bit rb, bit bchk, int n, bit ok, int code);
    @(negedge clk);
    readback = rb; busy_check = bchk; byte_count = CW'(n); start = 1;
    q_res.push_back({ok, 3'(code)});
    @(negedge clk);
    start = 0;
    #1 chk(busy == 1, "R1 busy after start", busy, 1);
  endtask

  task automatic feed(int n, logic [7:0] seed);
    for (int i = 0; i < n; i++) begin
      in_valid = 1; in_data = seed + 8'(i * 7);
      #1;
      while (!in_ready && busy) begin @(negedge clk); #1; end
      if (!busy) begin in_valid = 0; return; end
      q_w.push_back(in_data);
      @(negedge clk);
      in_valid = 0;
    end
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    #1;
    chk(prog_n && cs_n && write_n && !d_oe, "R10 released when idle",
        {prog_n, cs_n, write_n, d_oe}, 4'b1110);
  endtask

  task automatic load(bit bchk, int n, bit ok, int code, logic [7:0] seed);
    m_expect = n;
    launch(0, bchk, n, ok, code);
    feed(n, seed);
    wait_idle();
    q_w.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_sim();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 chk(prog_n && cs_n && write_n && !d_oe && !busy && !res_valid, "R10 reset state",
           {prog_n, cs_n, write_n, d_oe, busy}, 5'b11100);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R5 R8 normal load, with a start pulse during it (R1)
    m_expect = 6;
    launch(0, 0, 6, 1, 0);
    fork
      feed(6, 8'h11);
      begin
        repeat (20) @(negedge clk);
        readback = 1; start = 1;
        @(negedge clk); start = 0; readback = 0;
      end
    join
    wait_idle();
    chk(rx == 6, "R5 byte count", rx, 6);
    chk(q_res.size() == 0, "R1 single result", q_res.size(), 0);

    // R2 init never goes low
    m_lo_ok = 0; cs_fells = 0;
    load(0, 3, 0, 1, 8'h20);
    chk(cs_fells == 0, "R2 port stays closed", cs_fells, 0);
    m_lo_ok = 1;

    // R3 init never returns high
    m_hi_ok = 0; cs_fells = 0;
    load(0, 3, 0, 2, 8'h30);
    chk(cs_fells == 0, "R3 port stays closed", cs_fells, 0);
    m_hi_ok = 1;

    // R6 init drops after second byte
    m_drop = 2;
    load(0, 5, 0, 3, 8'h50);
    chk(rx == 2, "R6 stopped after drop", rx, 2);
    m_drop = -1;

    // R7 busy throttle short pulses
    m_busy_len = 3;
    load(1, 4, 1, 0, 8'h60);
    chk(rx == 4, "R7 throttled load", rx, 4);

    // R7 busy ignored when throttle off
    load(0, 3, 1, 0, 8'h70);

    // R7 busy stuck
    m_busy_len = 100;
    load(1, 4, 0, 4, 8'h80);
    chk(rx == 1, "R7 stopped on busy", rx, 1);
    m_busy_len = 0;

    // R8 done never rises
    m_done_ok = 0;
    load(0, 2, 0, 5, 8'h90);
    m_done_ok = 1;

    // R8 zero-length load
    load(0, 0, 1, 0, 8'h00);

    // R9 readback
    rb_cnt = 0; rb_tail = 0; rd_seen = 0; d_in = rb_base;
    for (int k = 0; k < 4; k++) q_r.push_back(rb_base + 8'(k + 1));
    launch(1, 0, 4, 1, 0);
    wait_idle();
    chk(rd_seen == 4, "R9 read count", rd_seen, 4);
    chk(rb_tail == 1, "R9 trailing clock", rb_tail, 1);
    chk(q_res.size() == 0, "R9 result seen", q_res.size(), 0);

    finish_sim();
  end
endmodule